// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block controls a bank of one-time-programmable fuse words and keeps a shadow copy of each word for fast reads. Software reaches it over a simple register bus. It writes a data word and then a command that starts a program operation on one fuse word or a reload of every shadow copy. It then polls a status register until the busy bit falls and reads the result code.

Each access to the fuse array is built from timed phases: setup, an active strobe and relax. The cycle counts of these phases come from four programmable fields: wait, relax, read strobe and program strobe. The fuse array is modelled inside the block. Fuse bits only ever change from 0 to 1. Each word is either in write-once mode or in accumulate mode, and each word has a lock bit. Rejected or failed operations leave the fuses unchanged and set a sticky error flag. After a successful program, the shadow copy of the word just programmed is refreshed automatically.

Top module: `otp_fuse_ctrl`

Register map (byte addresses on `bus_addr`):

| Offset | Register | Access | Contents |
|---|---|---|---|
| 0x00 | status | read | bit0 busy, bit1 error (sticky), bits 6:4 result code |
| 0x04 | command | write | bit0 program, bit1 reload, bit2 lock, bits 15:8 word index |
| 0x08 | program data | read/write | the word ORed into the fuses by the next program |
| 0x0C | error clear | write | a 1 in bit1 clears the error flag; other bits have no effect |
| 0x10 | timing | read/write | 7:0 wait, 15:8 relax, 23:16 read strobe, 31:24 program strobe |
| 0x14 | version | read | a fixed constant |
| 0x40 + 4·i | shadow i | read | shadow copy of fuse word i |

## Requirements
- R1: After reset, busy, the error flag and the result code read 0. Every shadow word reads 0. The timing register reads 0x0907_0102.
- R2: A program operation starts on the clock edge that accepts the command. From that edge, busy is high for the whole of the following sequence:
  - a setup phase of relax+1 cycles;
  - a program strobe (`fa_pgm_strobe`) of (progstrobe+1) − 2·(relax+1) cycles;
  - a relax phase of relax+1 cycles;
  - the read of that word, as described in R3;
  - one final cycle.
- R3: Each word read consists of wait+1 setup cycles followed by a read strobe (`fa_rd_strobe`) of (readstrobe+1) − 2·(relax+1) cycles. A reload reads words 0 to NWORDS−1 in this way, one after another, and then spends one final busy cycle.
- R4: A word in write-once mode (set by parameter `ECC_MAP`, default words 0–3) that has been programmed once cannot be programmed again. A second attempt gives result code 2 and leaves the word unchanged.
- R5: A word in accumulate mode can be programmed many times. Each program ORs the program data into the word's existing fuse bits.
- R6: A program with the lock bit set puts the word in write-once mode and locks it. Any later program to that word gives result code 3 and changes nothing.
- R7: A reload copies every fuse word into its shadow. If the read strobe length from R3 would be less than 1 cycle, the reload fails at once with result code 4 and every shadow is left unchanged.
- R8: The result code is 0 for success, 1 for access error, 2 for program fail, 3 for locked and 4 for reload error. It is updated on the edge where busy falls, together with the error flag, which is set by any nonzero code. The error flag stays set until a write to the error-clear register has bit1 set. A clear write with bit1 low has no effect.
- R9: A program to a word index of NWORDS or above, or a command with both the program bit and the reload bit set, gives result code 1 and changes nothing.
- R10: After a successful program, the shadow of the programmed word equals the new fuse value.
- R11: While busy is high, writes to the command, program-data and timing registers are ignored.
- R12: The version register always reads the constant given by parameter `VERSION` (default 0x0003_0107).
- R13: A program whose program strobe or read strobe length (from R2 and R3) would be less than 1 cycle fails at once with result code 2 and leaves the fuses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| busy | output | 1 | High while an operation is in progress |
| fa_pgm_strobe | output | 1 | Active program strobe to the fuse array |
| fa_rd_strobe | output | 1 | Active read strobe to the fuse array |
| fa_addr | output | IW | Fuse word currently being accessed |

## Verification
Some properties are checked on every cycle:
- the two strobes are never active together;
- a strobe is never active outside busy;
- fuse bits never fall and lock bits never clear;
- the error flag drops only on a clear write;
- a program strobe never starts on a write-once word that has already been used.

Other behaviour can only be shown by the bench's scenarios: the exact phase lengths under two timing settings, the result code chosen for each kind of rejection, the OR accumulation, the refresh of shadows after a program or a reload, and the fact that writes during busy are ignored. The bench predicts the busy and strobe waveform for every cycle and compares the register contents read back after each operation.

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
  parameter int NWORDS = 8,
  parameter int DW = 32,
  parameter logic [NWORDS-1:0] ECC_MAP = 8'h0F,
  parameter logic [31:0] VERSION = 32'h0003_0107,
  localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          busy,
  output logic          fa_pgm_strobe,
  output logic          fa_rd_strobe,
  output logic [IW-1:0] fa_addr
);
  localparam logic [2:0] C_OK = 3'd0, C_ACC = 3'd1, C_PFAIL = 3'd2, C_LOCK = 3'd3, C_RLERR = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_PSET, S_PSTB, S_PRLX, S_RSET, S_RSTB, S_FIN} st_t;
  st_t st;

  logic [DW-1:0]     fuse   [NWORDS];
  logic [DW-1:0]     shadow [NWORDS];
  logic [NWORDS-1:0] used, locked, ecc_force;
  logic [7:0]        t_wait, t_relax, t_srd, t_spg;
  logic [DW-1:0]     pdata;
  logic [9:0]        cnt;
  logic [IW-1:0]     idx;
  logic              full_rl, lock_req, error;
  logic [2:0]        code, pend, start_code;

  wire [10:0] rel2  = ({3'b0, t_relax} + 11'd1) << 1;
  wire [10:0] spg1  = {3'b0, t_spg} + 11'd1;
  wire [10:0] srd1  = {3'b0, t_srd} + 11'd1;
  wire        p_ok  = spg1 > rel2;
  wire        r_ok  = srd1 > rel2;
  wire [10:0] p_len = spg1 - rel2;
  wire [10:0] r_len = srd1 - rel2;

  assign busy          = (st != S_IDLE);
  assign fa_pgm_strobe = (st == S_PSTB);
  assign fa_rd_strobe  = (st == S_RSTB);
  assign fa_addr       = idx;

  wire          wr_cmd   = bus_wr && bus_addr == 8'h04 && !busy;
  wire          clr_err  = bus_wr && bus_addr == 8'h0C && bus_wdata[1];
  wire [7:0]    cmd_word = bus_wdata[15:8];
  wire [IW-1:0] widx     = cmd_word[IW-1:0];
  wire          in_range = {24'b0, cmd_word} < NWORDS;
  wire          ecc_now  = ECC_MAP[widx] | ecc_force[widx];

  always_comb begin
    start_code = C_OK;
    if (bus_wdata[0] && bus_wdata[1]) start_code = C_ACC;
    else if (bus_wdata[0]) begin
      if (!in_range) start_code = C_ACC;
      else if (locked[widx]) start_code = C_LOCK;
      else if (ecc_now && used[widx]) start_code = C_PFAIL;
      else if (!p_ok || !r_ok) start_code = C_PFAIL;
    end else if (!r_ok) start_code = C_RLERR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 0; i < NWORDS; i++) begin
        fuse[i] <= '0;
        shadow[i] <= '0;
      end
      used <= '0; locked <= '0; ecc_force <= '0;
      t_wait <= 8'd2; t_relax <= 8'd1; t_srd <= 8'd7; t_spg <= 8'd9;
      pdata <= '0; cnt <= '0; idx <= '0;
      full_rl <= 1'b0; lock_req <= 1'b0; error <= 1'b0;
      code <= C_OK; pend <= C_OK;
    end else begin
      if (bus_wr && bus_addr == 8'h08 && !busy) pdata <= bus_wdata[DW-1:0];
      if (bus_wr && bus_addr == 8'h10 && !busy)
        {t_spg, t_srd, t_relax, t_wait} <= bus_wdata;
      if (clr_err) error <= 1'b0;
      case (st)
        S_IDLE: if (wr_cmd && (bus_wdata[0] || bus_wdata[1])) begin
          pend <= start_code;
          if (start_code != C_OK) st <= S_FIN;
          else if (bus_wdata[0]) begin
            st <= S_PSET; cnt <= {2'b0, t_relax}; idx <= widx;
            lock_req <= bus_wdata[2]; full_rl <= 1'b0;
          end else begin
            st <= S_RSET; cnt <= {2'b0, t_wait}; idx <= '0; full_rl <= 1'b1;
          end
        end
        S_PSET: if (cnt == 0) begin st <= S_PSTB; cnt <= p_len[9:0] - 10'd1; end
                else cnt <= cnt - 10'd1;
        S_PSTB: if (cnt == 0) begin
          fuse[idx] <= fuse[idx] | pdata;
          used[idx] <= 1'b1;
          if (lock_req) begin locked[idx] <= 1'b1; ecc_force[idx] <= 1'b1; end
          st <= S_PRLX; cnt <= {2'b0, t_relax};
        end else cnt <= cnt - 10'd1;
        S_PRLX: if (cnt == 0) begin st <= S_RSET; cnt <= {2'b0, t_wait}; end
                else cnt <= cnt - 10'd1;
        S_RSET: if (cnt == 0) begin st <= S_RSTB; cnt <= r_len[9:0] - 10'd1; end
                else cnt <= cnt - 10'd1;
        S_RSTB: if (cnt == 0) begin
          shadow[idx] <= fuse[idx];
          if (full_rl && idx != IW'(NWORDS - 1)) begin
            idx <= idx + 1'b1; st <= S_RSET; cnt <= {2'b0, t_wait};
          end else st <= S_FIN;
        end else cnt <= cnt - 10'd1;
        S_FIN: begin
          st <= S_IDLE;
          code <= pend;
          if (pend != C_OK) error <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [7:0] sh_off = bus_addr - 8'h40;
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      8'h00: bus_rdata = {25'b0, code, 2'b0, error, busy};
      8'h08: bus_rdata = 32'(pdata);
      8'h10: bus_rdata = {t_spg, t_srd, t_relax, t_wait};
      8'h14: bus_rdata = VERSION;
      default:
        if (bus_addr >= 8'h40 && {26'b0, sh_off[7:2]} < NWORDS && sh_off[1:0] == 2'b0)
          bus_rdata = 32'(shadow[sh_off[7:2]]);
    endcase
  end

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(fa_pgm_strobe && fa_rd_strobe));
  a_r2_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_pgm_strobe || fa_rd_strobe) |-> busy);
  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !clr_err) |=> error);
  a_r6_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (locked & $past(locked)) == $past(locked));
  a_r4_no_ecc_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fa_pgm_strobe) |-> !((ECC_MAP[idx] | ecc_force[idx]) && used[idx]));
  for (genvar g = 0; g < NWORDS; g++) begin : g_mono
    a_r5_fuse_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse[g] & $past(fuse[g])) == $past(fuse[g]));
  end
endmodule

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NW = 8;
  localparam logic [NW-1:0] EMAP = 8'h0F;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic busy, fa_pgm_strobe, fa_rd_strobe;
  logic [2:0] fa_addr;

  otp_fuse_ctrl u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .fa_pgm_strobe(fa_pgm_strobe), .fa_rd_strobe(fa_rd_strobe), .fa_addr(fa_addr));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  logic [2:0] wq[$];
  bit mon_on = 0;
  int m_wait = 2, m_relax = 1, m_srd = 7, m_spg = 9;
  logic [31:0] m_fuse[NW], m_pdata = 0;
  bit m_used[NW], m_lock[NW], m_eccf[NW];
  bit m_err = 0;
  logic [2:0] m_code = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    logic [2:0] e;
    e = (wq.size() > 0) ? wq.pop_front() : 3'b000;
    chk("R2/R3 waveform", {29'b0, busy, fa_pgm_strobe, fa_rd_strobe}, {29'b0, e});
  end

  task automatic push(int n, logic [2:0] v);
    for (int i = 0; i < n; i++) wq.push_back(v);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, bit is_cmd);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    if (is_cmd) model_cmd(d);
    @(negedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic model_cmd(logic [31:0] d);
    int w, pp, rp;
    logic [2:0] c;
    w = d[15:8];
    pp = (m_spg + 1) - 2 * (m_relax + 1);
    rp = (m_srd + 1) - 2 * (m_relax + 1);
    c = 0;
    if (d[0] && d[1]) c = 1;
    else if (d[0]) begin
      if (w >= NW) c = 1;
      else if (m_lock[w]) c = 3;
      else if ((EMAP[w] || m_eccf[w]) && m_used[w]) c = 2;
      else if (pp < 1 || rp < 1) c = 2;
    end else if (rp < 1) c = 4;
    if (c != 0) push(1, 3'b100);
    else if (d[0]) begin
      push(m_relax + 1, 3'b100); push(pp, 3'b110); push(m_relax + 1, 3'b100);
      push(m_wait + 1, 3'b100); push(rp, 3'b101); push(1, 3'b100);
      m_fuse[w] = m_fuse[w] | m_pdata; m_used[w] = 1;
      if (d[2]) begin m_lock[w] = 1; m_eccf[w] = 1; end
    end else begin
      for (int i = 0; i < NW; i++) begin push(m_wait + 1, 3'b100); push(rp, 3'b101); end
      push(1, 3'b100);
    end
    m_code = c;
    if (c != 0) m_err = 1;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); #1; bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle;
    while (wq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_pdata(logic [31:0] d); wr(8'h08, d, 0); m_pdata = d; endtask
  task automatic set_timing(int w, int r, int s, int p);
    wr(8'h10, {p[7:0], s[7:0], r[7:0], w[7:0]}, 0);
    m_wait = w; m_relax = r; m_srd = s; m_spg = p;
  endtask
  task automatic pgm(int w, bit lk);
    wr(8'h04, {16'b0, w[7:0], 5'b0, lk, 2'b01}, 1); wait_idle();
  endtask

  task automatic check_status(string req);
    logic [31:0] s;
    rd(8'h00, s);
    chk(req, s, {25'b0, m_code, 2'b0, m_err, 1'b0});
  endtask
  task automatic check_shadows(string req);
    logic [31:0] s;
    for (int i = 0; i < NW; i++) begin
      rd(8'h40 + 8'(4 * i), s); chk(req, s, m_fuse[i]);
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NW; i++) begin m_fuse[i] = 0; m_used[i] = 0; m_lock[i] = 0; m_eccf[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    mon_on = 1;
    check_status("R1 status");
    check_shadows("R1 shadows");
    rd(8'h10, v); chk("R1 timing", v, 32'h0907_0102);
    rd(8'h14, v); chk("R12 version", v, 32'h0003_0107);

    set_pdata(32'h0000_00A5); pgm(5, 0);
    check_status("R10 status"); check_shadows("R10 shadow");
    set_pdata(32'h0000_5A00); pgm(5, 0);
    rd(8'h54, v); chk("R5 accumulate", v, 32'h0000_5AA5);

    set_pdata(32'h0000_1234); pgm(1, 0);
    set_pdata(32'hFFFF_0000); pgm(1, 0);
    check_status("R4 write-once code");
    rd(8'h44, v); chk("R4 word unchanged", v, 32'h0000_1234);
    wr(8'h0C, 32'h0000_0001, 0);
    check_status("R8 clear bit1 low ignored");
    wr(8'h0C, 32'h0000_0002, 0); m_err = 0;
    check_status("R8 error cleared");

    set_pdata(32'h0000_0F00); pgm(6, 1);
    check_status("R6 lock ok");
    set_pdata(32'h0000_00F0); pgm(6, 0);
    check_status("R6 locked code");
    rd(8'h58, v); chk("R6 word unchanged", v, 32'h0000_0F00);
    wr(8'h0C, 32'h2, 0); m_err = 0;

    pgm(20, 0); check_status("R9 out of range");
    wr(8'h04, 32'h0000_0303, 1); wait_idle(); check_status("R9 both bits");
    wr(8'h0C, 32'h2, 0); m_err = 0;

    set_timing(4, 2, 12, 15);
    set_pdata(32'h8000_0001); pgm(7, 0);
    check_status("R2 new timing"); check_shadows("R10 after timing");
    wr(8'h04, 32'h0000_0002, 1); wait_idle();
    check_status("R7 reload ok"); check_shadows("R7 reload");

    wr(8'h04, 32'h0000_0001 | (32'd3 << 8), 1);
    wr(8'h10, 32'h0101_0101, 0);
    wr(8'h08, 32'hDEAD_BEEF, 0);
    wr(8'h04, 32'h0000_0401, 0);
    wait_idle();
    rd(8'h10, v); chk("R11 timing kept", v, 32'h0F0C_0204);
    rd(8'h08, v); chk("R11 pdata kept", v, 32'h8000_0001);
    check_shadows("R11 shadows");

    set_timing(1, 2, 3, 15);
    wr(8'h04, 32'h0000_0002, 1); wait_idle();
    check_status("R7 reload error");
    check_shadows("R7 shadows unchanged");
    wr(8'h0C, 32'h2, 0); m_err = 0;
    set_pdata(32'h0000_00FF); pgm(4, 0);
    check_status("R13 bad timing");
    rd(8'h50, v); chk("R13 word unchanged", v, 32'h0);
    set_timing(1, 2, 15, 5);
    pgm(4, 0);
    check_status("R13 bad program strobe");
    rd(8'h50, v); chk("R13 still unchanged", v, 32'h0);

    mon_on = 0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule